// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits in the column-command path of an SDRAM controller. Each accepted read or write column command gives a start column and a burst mode. From these the block produces one column address per clock for the whole burst. The burst mode covers the length, sequential or interleave order, and the single-location write option.

For reads, it delays a beat marker by the programmed CAS latency, so the data path knows when read data comes back. That marker is gated per byte lane with a mask that takes effect two clocks after it is sampled. For writes, it gives a per-lane write enable that the mask blocks in the same clock.

A later column command takes over from a running burst. A burst-stop pulse cuts a burst short at any length, including full-page bursts that would otherwise wrap around the page for ever.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and in the first cycle after it, `beat_valid`, `rd_valid`, `wr_lane_en` and `rd_lane_oe` are all zero.
- R2: A `start` sampled at a clock edge makes `beat_valid` high in the next cycle. In that cycle `beat_col` equals the sampled `start_col` and `beat_write` equals the sampled `is_write`. Later beats follow one per clock.
- R3: Burst length codes on `len_code` are 0=1 beat, 1=2 beats, 2=4 beats, 3=8 beats and 7=full page. Codes 4, 5 and 6 give one beat. After the last beat of a fixed-length burst, `beat_valid` is low unless a new `start` was sampled.
- R4: With `ilv`=0 and a fixed length L, the low log2(L) column bits count up from the start offset and wrap inside the aligned group of L columns. The upper bits are unchanged. For example, L=4 from offset 2 gives 2,3,0,1.
- R5: With `ilv`=1 and a fixed length L, beat n has the low log2(L) bits equal to the start offset XOR n. For example, L=8 from offset 5 gives 5,4,7,6,1,0,3,2.
- R6: A full-page burst walks all 2^COL_W columns in ascending order, whatever `ilv` is. It wraps from the top column to 0 and continues until a stop or a new start.
- R7: A `stop` sampled without `start` during a burst makes `beat_valid` low in the next cycle. Read beats already presented still produce their `rd_valid`.
- R8: A `start` sampled during a burst restarts addressing from the new column in the next cycle. When `start` and `stop` are sampled together, the start wins.
- R9: With `single_wr`=1, a write burst has exactly one beat. A read burst keeps its programmed length.
- R10: `rd_valid` is high exactly `cas_lat` cycles after each cycle that shows a read beat. `cas_lat` may be 1, 2 or 3, and 0 acts as 1.
- R11: `wr_lane_en[i]` is high when the current cycle shows a write beat and `mask[i]` is low in that same cycle. Otherwise it is zero.
- R12: `rd_lane_oe[i]` is high when `rd_valid` is high and `mask[i]` was low two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Column command pulse |
| is_write | input | 1 | 1 = write command, 0 = read command |
| start_col | input | COL_W (10) | First column of the burst |
| len_code | input | 3 | Burst length code |
| ilv | input | 1 | 1 = interleave order, 0 = sequential order |
| single_wr | input | 1 | Writes use a single beat |
| cas_lat | input | CL_W (2) | CAS latency in clocks |
| stop | input | 1 | Burst-stop pulse |
| mask | input | MASK_W (2) | Byte-lane mask, 1 = masked |
| beat_valid | output | 1 | A beat address is presented this cycle |
| beat_write | output | 1 | The presented beat belongs to a write |
| beat_col | output | COL_W (10) | Column of the presented beat |
| rd_valid | output | 1 | Read data due this cycle |
| rd_lane_oe | output | MASK_W (2) | Per-lane read drive enable |
| wr_lane_en | output | MASK_W (2) | Per-lane write enable |

## Verification
Two pairs of events can land in one cycle. The first pair is a new column command and a burst stop. The bench raises both on the second beat of an eight-beat read. It then expects the new four-beat sequence to begin in the next cycle, with the old burst dropped and no gap. The second pair is a stop and the tail of the read latency line. The bench stops a read at CAS latency 3 and checks that beat addresses cease at once, while `rd_valid` still covers exactly the three beats already issued.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  localparam logic [2:0] BLEN_PAGE = 3'd7;

  typedef struct packed {
    logic [1:0] lg;    // log2 of fixed burst length
    logic       page;  // full-page burst
  } blen_t;

  // Decode the length code; one_beat forces a single-beat burst.
  function automatic blen_t blen_decode(logic [2:0] code, logic one_beat);
    blen_t r;
    r.lg   = 2'd0;
    r.page = 1'b0;
    if (!one_beat) begin
      if (code == BLEN_PAGE) r.page = 1'b1;
      else if (!code[2])     r.lg   = code[1:0];
    end
    return r;
  endfunction

endpackage

// File: rtl/colgen_seq.sv
module colgen_seq
  import colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             ilv,
  input  logic             single_wr,
  input  logic             stop,
  output logic             beat_valid,
  output logic             beat_write,
  output logic [COL_W-1:0] beat_col,
  output logic             burst_last
);

  typedef logic [COL_W-1:0] col_t;

  // Low-bit mask of the wrap group.
  function automatic col_t grp_mask(blen_t b);
    if (b.page) return '1;
    return (col_t'(1) << b.lg) - col_t'(1);
  endfunction

  // Column of beat idx: upper bits from base, low bits stepped or XORed.
  function automatic col_t beat_addr(col_t base, col_t idx, col_t msk, logic xo);
    col_t low;
    low = xo ? (base ^ idx) : (base + idx);
    return (base & ~msk) | (low & msk);
  endfunction

  logic  act_q, wr_q, ilv_q;
  col_t  base_q, idx_q, msk;
  blen_t blen_q, blen_new;

  assign blen_new   = blen_decode(len_code, is_write & single_wr);
  assign msk        = grp_mask(blen_q);
  assign burst_last = act_q && !blen_q.page && (idx_q == msk);
  assign beat_col   = beat_addr(base_q, idx_q, msk, ilv_q);
  assign beat_valid = act_q;
  assign beat_write = wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      blen_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      wr_q   <= is_write;
      ilv_q  <= ilv & ~blen_new.page;
      base_q <= start_col;
      idx_q  <= '0;
      blen_q <= blen_new;
    end else if (act_q) begin
      if (stop || burst_last) act_q <= 1'b0;
      else                    idx_q <= idx_q + col_t'(1);
    end
  end

endmodule

// File: rtl/colgen_rdpipe.sv
module colgen_rdpipe #(
  parameter  int MASK_W   = 2,
  parameter  int CL_MAX   = 3,
  parameter  int MASK_LAT = 2,
  localparam int CL_W     = $clog2(CL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_beat,
  input  logic [CL_W-1:0]   cas_lat,
  input  logic [MASK_W-1:0] mask,
  output logic              rd_valid,
  output logic [MASK_W-1:0] rd_lane_oe
);

  logic [CL_MAX-1:0] vld_q;
  logic [MASK_W-1:0] mask_late;

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[CL_MAX-2:0], rd_beat};
  end

  always_comb begin
    int sel;
    sel = (cas_lat == '0) ? 1 : int'(cas_lat);
    if (sel > CL_MAX) sel = CL_MAX;
    rd_valid = 1'b0;
    for (int i = 0; i < CL_MAX; i++)
      if (sel == i + 1) rd_valid = vld_q[i];
  end

  generate
    if (MASK_LAT == 0) begin : g_mask_now
      assign mask_late = mask;
    end else begin : g_mask_dly
      logic [MASK_W-1:0] mdly_q [MASK_LAT];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < MASK_LAT; i++) mdly_q[i] <= '0;
        end else begin
          mdly_q[0] <= mask;
          for (int i = 1; i < MASK_LAT; i++) mdly_q[i] <= mdly_q[i-1];
        end
      end
      assign mask_late = mdly_q[MASK_LAT-1];
    end
  endgenerate

  assign rd_lane_oe = {MASK_W{rd_valid}} & ~mask_late;

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter  int COL_W  = 10,
  parameter  int MASK_W = 2,
  parameter  int CL_MAX = 3,
  localparam int CL_W   = $clog2(CL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic [COL_W-1:0]  start_col,
  input  logic [2:0]        len_code,
  input  logic              ilv,
  input  logic              single_wr,
  input  logic [CL_W-1:0]   cas_lat,
  input  logic              stop,
  input  logic [MASK_W-1:0] mask,
  output logic              beat_valid,
  output logic              beat_write,
  output logic [COL_W-1:0]  beat_col,
  output logic              rd_valid,
  output logic [MASK_W-1:0] rd_lane_oe,
  output logic [MASK_W-1:0] wr_lane_en
);

  // Named internal events for the checker.
  logic burst_last;
  logic rd_beat;

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .is_write   (is_write),
    .start_col  (start_col),
    .len_code   (len_code),
    .ilv        (ilv),
    .single_wr  (single_wr),
    .stop       (stop),
    .beat_valid (beat_valid),
    .beat_write (beat_write),
    .beat_col   (beat_col),
    .burst_last (burst_last)
  );

  assign rd_beat    = beat_valid & ~beat_write;
  assign wr_lane_en = {MASK_W{beat_valid & beat_write}} & ~mask;

  colgen_rdpipe #(.MASK_W(MASK_W), .CL_MAX(CL_MAX), .MASK_LAT(2)) u_rdpipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_beat    (rd_beat),
    .cas_lat    (cas_lat),
    .mask       (mask),
    .rd_valid   (rd_valid),
    .rd_lane_oe (rd_lane_oe)
  );

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int COL_W  = 10,
  parameter int MASK_W = 2,
  parameter int CL_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              stop,
  input logic              is_write,
  input logic [COL_W-1:0]  start_col,
  input logic [CL_W-1:0]   cas_lat,
  input logic [MASK_W-1:0] mask,
  input logic              beat_valid,
  input logic              beat_write,
  input logic [COL_W-1:0]  beat_col,
  input logic              burst_last,
  input logic              rd_beat,
  input logic              rd_valid,
  input logic [MASK_W-1:0] wr_lane_en,
  input logic [MASK_W-1:0] rd_lane_oe
);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_valid && beat_col == $past(start_col) && beat_write == $past(is_write)));

  // R7
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !beat_valid);

  // R3
  last_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_last && !start) |=> !beat_valid);

  // R10
  cl_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_beat && cas_lat == CL_W'(1)) |=> (rd_valid || cas_lat != CL_W'(1)));

  // R11
  wr_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_lane_en) |-> (beat_valid && beat_write));

  // R12
  rd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_lane_oe) |-> rd_valid);

  // R12
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask, 2) & rd_lane_oe) == '0);

endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W), .MASK_W(MASK_W), .CL_W(CL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .stop       (stop),
  .is_write   (is_write),
  .start_col  (start_col),
  .cas_lat    (cas_lat),
  .mask       (mask),
  .beat_valid (beat_valid),
  .beat_write (beat_write),
  .beat_col   (beat_col),
  .burst_last (burst_last),
  .rd_beat    (rd_beat),
  .rd_valid   (rd_valid),
  .wr_lane_en (wr_lane_en),
  .rd_lane_oe (rd_lane_oe)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;

  localparam int COL_W  = 10;
  localparam int MASK_W = 2;
  localparam int PAGE   = 1 << COL_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              is_write = 1'b0;
  logic [COL_W-1:0]  start_col = '0;
  logic [2:0]        len_code = '0;
  logic              ilv = 1'b0;
  logic              single_wr = 1'b0;
  logic [1:0]        cas_lat = 2'd1;
  logic              stop = 1'b0;
  logic [MASK_W-1:0] mask = '0;
  logic              beat_valid, beat_write, rd_valid;
  logic [COL_W-1:0]  beat_col;
  logic [MASK_W-1:0] rd_lane_oe, wr_lane_en;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  sdram_burst_colgen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
    .start_col(start_col), .len_code(len_code), .ilv(ilv),
    .single_wr(single_wr), .cas_lat(cas_lat), .stop(stop), .mask(mask),
    .beat_valid(beat_valid), .beat_write(beat_write), .beat_col(beat_col),
    .rd_valid(rd_valid), .rd_lane_oe(rd_lane_oe), .wr_lane_en(wr_lane_en)
  );

  // Vector: {len code, interleave, start column, write}
  localparam logic [14:0] VEC [0:9] = '{
    {3'd2, 1'b0, 10'd2,    1'b0},
    {3'd3, 1'b1, 10'd5,    1'b0},
    {3'd3, 1'b0, 10'd1021, 1'b0},
    {3'd2, 1'b1, 10'd422,  1'b0},
    {3'd1, 1'b0, 10'd7,    1'b0},
    {3'd0, 1'b1, 10'd513,  1'b0},
    {3'd1, 1'b1, 10'd300,  1'b1},
    {3'd3, 1'b0, 10'd12,   1'b1},
    {3'd5, 1'b0, 10'd77,   1'b0},
    {3'd2, 1'b0, 10'd1023, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // -1 means full page
  function automatic int beats_of(int code, bit one);
    if (one) return 1;
    if (code == 7) return -1;
    if (code < 4) return 1 << code;
    return 1;
  endfunction

  function automatic int col_of(int col, int n, int len, bit xo);
    int off, grp;
    if (len < 0) return (col + n) % PAGE;
    off = col % len;
    grp = col - off;
    if (xo) return grp + (off ^ n);
    return grp + ((off + n) % len);
  endfunction

  // Called at a falling edge; returns at the falling edge of beat 0.
  task automatic issue(input int code, input bit xo, input int col, input bit wr);
    start     = 1'b1;
    len_code  = code[2:0];
    ilv       = xo;
    start_col = col[COL_W-1:0];
    is_write  = wr;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_vec(input int code, input bit xo, input int col, input bit wr);
    int len;
    len = beats_of(code, wr & single_wr);
    issue(code, xo, col, wr);
    for (int n = 0; n < len; n++) begin
      #1;
      chk("R2 beat_valid", beat_valid, 1);
      chk("R2 beat_write", beat_write, wr);
      chk(xo && len > 1 ? "R5 column" : "R4 column", beat_col, col_of(col, n, len, xo));
      chk("R11 wr_lane_en", wr_lane_en, wr ? 3 : 0);
      @(negedge clk);
    end
    #1;
    chk("R3 burst end", beat_valid, 0);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [14:0] v;
    repeat (3) @(negedge clk);
    chk("R1 beat_valid in reset", beat_valid, 0);
    chk("R1 rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 beat_valid", beat_valid, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 wr_lane_en", wr_lane_en, 0);
    chk("R1 rd_lane_oe", rd_lane_oe, 0);

    // Table walk: R3, R4, R5, R11
    for (int i = 0; i < 10; i++) begin
      v = VEC[i];
      run_vec(int'(v[14:12]), v[11], int'(v[10:1]), v[0]);
    end

    // R9: single-location write vs read
    single_wr = 1'b1;
    run_vec(3, 1'b0, 40, 1'b1);
    run_vec(2, 1'b0, 40, 1'b0);
    single_wr = 1'b0;

    // R10: read valid at each CAS latency
    for (int c = 1; c <= 3; c++) begin
      cas_lat = c[1:0];
      issue(2, 1'b0, 0, 1'b0);
      for (int t = 0; t < 9; t++) begin
        #1;
        chk($sformatf("R10 rd_valid cl=%0d t=%0d", c, t), rd_valid, (t >= c && t < c + 4) ? 1 : 0);
        @(negedge clk);
      end
    end

    // R12: read mask two cycles late
    cas_lat = 2'd2;
    issue(2, 1'b0, 0, 1'b0);
    for (int t = 0; t < 7; t++) begin
      mask = (t == 0) ? 2'b01 : 2'b00;
      #1;
      chk($sformatf("R12 rd_lane_oe t=%0d", t), rd_lane_oe,
          (t == 2) ? 2 : ((t >= 3 && t <= 5) ? 3 : 0));
      @(negedge clk);
    end
    mask = '0;

    // R11: write mask same cycle
    issue(2, 1'b0, 8, 1'b1);
    for (int t = 0; t < 4; t++) begin
      mask = (t == 1) ? 2'b10 : 2'b00;
      #1;
      chk($sformatf("R11 wr_lane_en t=%0d", t), wr_lane_en, (t == 1) ? 1 : 3);
      @(negedge clk);
    end
    mask = '0;
    repeat (2) @(negedge clk);

    // R7: stop, with read data still owed at CL=3
    cas_lat = 2'd3;
    issue(3, 1'b0, 0, 1'b0);
    for (int t = 0; t < 8; t++) begin
      stop = (t == 2);
      #1;
      chk($sformatf("R7 beat_valid t=%0d", t), beat_valid, (t <= 2) ? 1 : 0);
      chk($sformatf("R7 rd_valid t=%0d", t), rd_valid, (t >= 3 && t <= 5) ? 1 : 0);
      @(negedge clk);
    end
    stop = 1'b0;

    // R8: new start together with stop mid-burst
    issue(3, 1'b0, 0, 1'b0);
    for (int t = 0; t < 7; t++) begin
      if (t == 1) begin
        start = 1'b1; stop = 1'b1; start_col = 10'd100; len_code = 3'd2;
      end else begin
        start = 1'b0; stop = 1'b0;
      end
      #1;
      if (t < 6) begin
        chk($sformatf("R8 valid t=%0d", t), beat_valid, 1);
        chk($sformatf("R8 column t=%0d", t), beat_col, (t < 2) ? t : 98 + t);
      end else chk("R8 end", beat_valid, 0);
      @(negedge clk);
    end

    // R6: full page, interleave ignored, wrap at page top
    issue(7, 1'b1, 1020, 1'b0);
    for (int t = 0; t < 10; t++) begin
      stop = (t == 8);
      #1;
      if (t <= 8) chk($sformatf("R6 column t=%0d", t), beat_col, (1020 + t) % PAGE);
      else        chk("R6 stopped", beat_valid, 0);
      @(negedge clk);
    end
    stop = 1'b0;

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule